// File: doc/BRIEF.md
# Bus Output Shifter and Limiter

This unit sits on the path from the data register file to the 20-bit data bus. Each clock it takes one source value, scales it by a power of two chosen by a two-bit mode field, rounds the result to the nearest bus step, and clamps it to the signed 20-bit range. The registered result and a flag that marks a clamped transfer appear on the next clock edge.

A source is either a 48-bit accumulator or a 20-bit general register. An accumulator is read as three fields: guard bits 47:40, the bus-sized field 39:20, and fraction bits 19:0. The bus word is the bus-sized field after scaling, and the bit just below it sets the rounding. A 20-bit register is placed in the bus-sized field with zero fraction and sign-extended guard bits. Both sources then share one datapath, so the same scaling, rounding and clamping rules apply to each.

Top module: `oshl_bus_shifter`

## Requirements
- R1: While `rst_n` is low, `bus_out` is 0 and `limit_out` is 0.
- R2: Outputs update on the rising clock edge after the inputs are presented and hold their value until the next edge.
- R3: For a register source (`src_acc` = 0), `ds_sel` 00 passes the value unchanged, 10 doubles it and 11 multiplies it by four. All shifts preserve the sign.
- R4: For a register source with `ds_sel` = 01, the output is the value shifted right by one, plus the bit shifted out (round half up). It never sets `limit_out`.
- R5: For an accumulator source (`src_acc` = 1), the output is bits 39:20 of the accumulator after an arithmetic shift (01 right by one, 00 none, 10 left by one, 11 left by two), plus bit 19 of the shifted value.
- R6: A result above 2^19-1 makes `bus_out` 0x7FFFF and sets `limit_out`.
- R7: A result below -2^19 makes `bus_out` 0x80000 and sets `limit_out`. A clamped output always has the sign of the source.
- R8: A rounding increment that carries past the largest positive value is clamped to 0x7FFFF and sets `limit_out`.
- R9: Accumulator guard bits (47:40) take part in the result. Guard bits that are not a sign extension saturate the output even with no shift, and a right shift brings bit 40 into the output MSB.
- R10: When the rounded result fits in 20 signed bits, `limit_out` is 0. This includes exactly -2^19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ds_sel | input | 2 | Scale mode: 00 none, 01 right 1, 10 left 1, 11 left 2 |
| src_acc | input | 1 | 1 selects the accumulator input, 0 the register input |
| acc_in | input | 48 | Accumulator source value |
| reg_in | input | 20 | General register source value |
| bus_out | output | 20 | Scaled, rounded and clamped bus word |
| limit_out | output | 1 | High when the bus word was clamped |

## Verification
Register sources are tried with positive, negative and odd values under every mode. This separates correct arithmetic shifts from logical ones and shows whether right-shift rounding goes half up or truncates. Accumulators with fraction bits just at and just below one half show whether the round bit is taken from the right position for each mode. Values that sit exactly on the signed limits, one step beyond them, and one rounding step beyond them show whether the clamp threshold is off by one. Accumulators with non-sign guard bits show whether the upper field is ignored or discarded.

// File: rtl/oshl_pkg.sv
package oshl_pkg;

   typedef enum logic [1:0] {
      DS_NONE   = 2'b00,
      DS_RIGHT1 = 2'b01,
      DS_LEFT1  = 2'b10,
      DS_LEFT2  = 2'b11
   } ds_e;

   // Left-shift count applied to a frame that is later read one bit
   // lower, so a right shift by one becomes a left shift by zero.
   function automatic logic [1:0] lsh_of(input ds_e mode);
      case (mode)
         DS_RIGHT1: lsh_of = 2'd0;
         DS_NONE:   lsh_of = 2'd1;
         DS_LEFT1:  lsh_of = 2'd2;
         default:   lsh_of = 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/oshl_align.sv
// Places the selected source into the common accumulator frame.
module oshl_align #(
   parameter int ACC_W     = 48,
   parameter int FIELD_LSB = 20,
   parameter int BUS_W     = 20
) (
   input  logic             src_acc,
   input  logic [ACC_W-1:0] acc_in,
   input  logic [BUS_W-1:0] reg_in,
   output logic [ACC_W-1:0] frame
);
   localparam int GUARD_W = ACC_W - FIELD_LSB - BUS_W;

   logic [ACC_W-1:0] reg_frame;

   generate
      if (GUARD_W > 0) begin : g_guard
         assign reg_frame = {{GUARD_W{reg_in[BUS_W-1]}}, reg_in, {FIELD_LSB{1'b0}}};
      end else begin : g_noguard
         assign reg_frame = {reg_in, {FIELD_LSB{1'b0}}};
      end
   endgenerate

   assign frame = src_acc ? acc_in : reg_frame;
endmodule

// File: rtl/oshl_scale.sv
// Arithmetic scale followed by round-half-up to the bus field.
module oshl_scale #(
   parameter int ACC_W     = 48,
   parameter int FIELD_LSB = 20,
   parameter int MAX_LSH   = 2,
   localparam int EXT_W    = ACC_W + MAX_LSH + 1,
   localparam int Q_W      = EXT_W - FIELD_LSB,
   localparam int N_SH     = MAX_LSH + 2
) (
   input  logic [ACC_W-1:0]     frame,
   input  logic [1:0]           lsh,
   output logic signed [Q_W-1:0] quo
);
   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] cand [N_SH];
   logic [EXT_W-1:0] v;
   logic signed [Q_W-1:0] trunc_q;

   assign ext = {{(MAX_LSH+1){frame[ACC_W-1]}}, frame};

   generate
      for (genvar g = 0; g < N_SH; g++) begin : g_sh
         assign cand[g] = ext << g;
      end
   endgenerate

   always_comb begin
      v = cand[0];
      for (int i = 1; i < N_SH; i++)
         if (32'(lsh) == i) v = cand[i];
   end

   assign trunc_q = {v[EXT_W-1], v[EXT_W-1:FIELD_LSB+1]};
   assign quo     = trunc_q + Q_W'(v[FIELD_LSB]);
endmodule

// File: rtl/oshl_sat.sv
// Clamps a wide signed value to the bus width.
module oshl_sat #(
   parameter int IN_W  = 31,
   parameter int BUS_W = 20
) (
   input  logic signed [IN_W-1:0] q,
   output logic [BUS_W-1:0]       word,
   output logic                   lim
);
   localparam logic [BUS_W-1:0] POS_RAIL = {1'b0, {(BUS_W-1){1'b1}}};
   localparam logic [BUS_W-1:0] NEG_RAIL = {1'b1, {(BUS_W-1){1'b0}}};

   logic [IN_W-BUS_W:0] top;
   logic                fits;

   assign top  = q[IN_W-1:BUS_W-1];
   assign fits = (&top) | ~(|top);
   assign lim  = ~fits;
   assign word = fits ? q[BUS_W-1:0] : (q[IN_W-1] ? NEG_RAIL : POS_RAIL);
endmodule

// File: rtl/oshl_bus_shifter.sv
module oshl_bus_shifter #(
   parameter int ACC_W     = 48,
   parameter int FIELD_LSB = 20,
   parameter int BUS_W     = 20,
   parameter int MAX_LSH   = 2,
   localparam int EXT_W    = ACC_W + MAX_LSH + 1,
   localparam int Q_W      = EXT_W - FIELD_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ds_sel,
   input  logic             src_acc,
   input  logic [ACC_W-1:0] acc_in,
   input  logic [BUS_W-1:0] reg_in,
   output logic [BUS_W-1:0] bus_out,
   output logic             limit_out
);
   import oshl_pkg::*;

   generate
      if (FIELD_LSB < 1) begin : g_bad_lsb
         $error("FIELD_LSB must leave a round bit below the bus field");
      end
      if (FIELD_LSB + BUS_W > ACC_W) begin : g_bad_acc
         $error("bus field does not fit in the accumulator");
      end
      if (MAX_LSH != 2) begin : g_bad_lsh
         $error("mode encoding covers a left shift of exactly two");
      end
   endgenerate

   logic [ACC_W-1:0]      frame;
   logic signed [Q_W-1:0] quo;
   logic [BUS_W-1:0]      word;
   logic                  lim;

   oshl_align #(.ACC_W(ACC_W), .FIELD_LSB(FIELD_LSB), .BUS_W(BUS_W)) u_align (
      .src_acc (src_acc),
      .acc_in  (acc_in),
      .reg_in  (reg_in),
      .frame   (frame)
   );

   oshl_scale #(.ACC_W(ACC_W), .FIELD_LSB(FIELD_LSB), .MAX_LSH(MAX_LSH)) u_scale (
      .frame (frame),
      .lsh   (lsh_of(ds_e'(ds_sel))),
      .quo   (quo)
   );

   oshl_sat #(.IN_W(Q_W), .BUS_W(BUS_W)) u_sat (
      .q    (quo),
      .word (word),
      .lim  (lim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_out   <= '0;
         limit_out <= 1'b0;
      end else begin
         bus_out   <= word;
         limit_out <= lim;
      end
   end
endmodule

// File: rtl/oshl_bus_shifter_chk.sv
module oshl_bus_shifter_chk #(
   parameter int ACC_W = 48,
   parameter int BUS_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       ds_sel,
   input logic             src_acc,
   input logic [ACC_W-1:0] acc_in,
   input logic [BUS_W-1:0] reg_in,
   input logic [BUS_W-1:0] bus_out,
   input logic             limit_out
);
   localparam logic [BUS_W-1:0] POS_RAIL = {1'b0, {(BUS_W-1){1'b1}}};
   localparam logic [BUS_W-1:0] NEG_RAIL = {1'b1, {(BUS_W-1){1'b0}}};

   p_limit_rail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      limit_out |-> (bus_out == POS_RAIL || bus_out == NEG_RAIL));

   p_limit_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && limit_out) |->
         (bus_out[BUS_W-1] == $past(src_acc ? acc_in[ACC_W-1] : reg_in[BUS_W-1])));

   p_reg_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!src_acc && ds_sel == 2'b00)) |->
         (bus_out == $past(reg_in) && !limit_out));

   p_right_nolimit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!src_acc && ds_sel == 2'b01)) |-> !limit_out);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(src_acc) && $stable(ds_sel) && $stable(acc_in)
       && $stable(reg_in) && $past(rst_n, 2)) |=> $stable(bus_out));
endmodule

bind oshl_bus_shifter oshl_bus_shifter_chk #(.ACC_W(ACC_W), .BUS_W(BUS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ds_sel    (ds_sel),
   .src_acc   (src_acc),
   .acc_in    (acc_in),
   .reg_in    (reg_in),
   .bus_out   (bus_out),
   .limit_out (limit_out)
);

// File: tb/oshl_bus_shifter_test.sv
module oshl_bus_shifter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ds_sel = 2'b00;
   logic        src_acc = 1'b0;
   logic [47:0] acc_in = '0;
   logic [19:0] reg_in = '0;
   logic [19:0] bus_out;
   logic        limit_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   oshl_bus_shifter uut (
      .clk(clk), .rst_n(rst_n), .ds_sel(ds_sel), .src_acc(src_acc),
      .acc_in(acc_in), .reg_in(reg_in), .bus_out(bus_out), .limit_out(limit_out)
   );

   // Expected value: round(x * 2^s / 2^20) half up, clamped to 20 signed bits.
   function automatic void model(input logic [1:0] ds, input logic src,
                                 input logic [47:0] acc, input logic [19:0] r,
                                 output logic [19:0] q, output logic lim);
      longint x, num, res;
      int s1;
      if (src) x = longint'($signed(acc));
      else     x = longint'($signed(r)) * 64'sd1048576;
      case (ds)
         2'b00: s1 = 1;
         2'b01: s1 = 0;
         2'b10: s1 = 2;
         default: s1 = 3;
      endcase
      num = x * (64'sd1 <<< s1);
      res = (num + 64'sd1048576) >>> 21;
      if (res > 64'sd524287) begin q = 20'h7FFFF; lim = 1'b1; end
      else if (res < -64'sd524288) begin q = 20'h80000; lim = 1'b1; end
      else begin q = res[19:0]; lim = 1'b0; end
   endfunction

   task automatic check(input string req, input logic [19:0] exp_q, input logic exp_l);
      checks++;
      if (bus_out !== exp_q || limit_out !== exp_l) begin
         errors++;
         $display("FAIL %s: got out=%h lim=%b, expected out=%h lim=%b",
                  req, bus_out, limit_out, exp_q, exp_l);
      end
   endtask

   task automatic xfer(input string req, input logic [1:0] ds, input logic src,
                       input logic [47:0] acc, input logic [19:0] r);
      logic [19:0] eq;
      logic el;
      @(negedge clk);
      ds_sel = ds; src_acc = src; acc_in = acc; reg_in = r;
      @(negedge clk);
      model(ds, src, acc, r, eq, el);
      check(req, eq, el);
   endtask

   task automatic t_reset;
      @(negedge clk);
      ds_sel = 2'b11; src_acc = 1'b1; acc_in = 48'h01_00000_00000; reg_in = 20'h7FFFF;
      @(negedge clk);
      check("R1 reset", 20'h0, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_latency;
      xfer("R2 setup", 2'b00, 1'b0, '0, 20'h00011);
      @(negedge clk);
      reg_in = 20'h00022;
      #1 check("R2 before edge", 20'h00011, 1'b0);
      @(negedge clk);
      check("R2 after edge", 20'h00022, 1'b0);
   endtask

   task automatic t_reg_modes;
      xfer("R3 pass", 2'b00, 1'b0, '0, 20'h12345);
      check("R3 pass literal", 20'h12345, 1'b0);
      xfer("R3 left1", 2'b10, 1'b0, '0, 20'h12345);
      check("R3 left1 literal", 20'h2468A, 1'b0);
      xfer("R3 left2", 2'b11, 1'b0, '0, 20'h12345);
      check("R3 left2 literal", 20'h48D14, 1'b0);
      xfer("R3 neg left2", 2'b11, 1'b0, '0, 20'hFFFF0);
      check("R3 neg left2 literal", 20'hFFFC0, 1'b0);
   endtask

   task automatic t_reg_right;
      xfer("R4 pos odd", 2'b01, 1'b0, '0, 20'h00005);
      check("R4 pos odd literal", 20'h00003, 1'b0);
      xfer("R4 neg odd", 2'b01, 1'b0, '0, 20'hFFFFB);
      check("R4 neg odd literal", 20'hFFFFE, 1'b0);
      xfer("R4 max", 2'b01, 1'b0, '0, 20'h7FFFF);
      check("R4 max literal", 20'h40000, 1'b0);
      xfer("R4 min", 2'b01, 1'b0, '0, 20'h80000);
      check("R4 min literal", 20'hC0000, 1'b0);
   endtask

   task automatic t_acc_modes;
      for (int m = 0; m < 4; m++) begin
         xfer("R5 acc half", 2'(m), 1'b1, 48'h00_12345_80000, '0);
         xfer("R5 acc below half", 2'(m), 1'b1, 48'h00_12345_7FFFF, '0);
         xfer("R5 acc neg", 2'(m), 1'b1, 48'hFF_E1234_C0001, '0);
      end
      xfer("R5 acc none", 2'b00, 1'b1, 48'h00_12345_80000, '0);
      check("R5 acc none literal", 20'h12346, 1'b0);
   endtask

   task automatic t_saturate;
      xfer("R6 reg left1 pos", 2'b10, 1'b0, '0, 20'h40000);
      check("R6 literal", 20'h7FFFF, 1'b1);
      xfer("R6 acc left2 pos", 2'b11, 1'b1, 48'h00_30000_00000, '0);
      xfer("R7 reg left1 neg", 2'b10, 1'b0, '0, 20'hBFFFF);
      check("R7 literal", 20'h80000, 1'b1);
      xfer("R7 acc left1 neg", 2'b10, 1'b1, 48'hFF_A0000_00000, '0);
      xfer("R10 exact min", 2'b10, 1'b0, '0, 20'hC0000);
      check("R10 exact min literal", 20'h80000, 1'b0);
      xfer("R10 acc min", 2'b00, 1'b1, 48'hFF_80000_00000, '0);
   endtask

   task automatic t_round_carry;
      xfer("R8 carry", 2'b00, 1'b1, 48'h00_7FFFF_80000, '0);
      check("R8 literal", 20'h7FFFF, 1'b1);
      xfer("R8 no carry", 2'b00, 1'b1, 48'h00_7FFFF_7FFFF, '0);
      check("R10 no carry literal", 20'h7FFFF, 1'b0);
   endtask

   task automatic t_guard;
      xfer("R9 guard pos", 2'b00, 1'b1, 48'h01_00000_00000, '0);
      check("R9 guard pos literal", 20'h7FFFF, 1'b1);
      xfer("R9 guard neg", 2'b00, 1'b1, 48'hFF_00000_00000, '0);
      check("R9 guard neg literal", 20'h80000, 1'b1);
      xfer("R9 right bit40", 2'b01, 1'b1, 48'hFF_00000_00000, '0);
      check("R9 right bit40 literal", 20'h80000, 1'b0);
      xfer("R9 right near max", 2'b01, 1'b1, 48'h00_FFFFF_00000, '0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_reg_modes();
      t_reg_right();
      t_acc_modes();
      t_saturate();
      t_round_carry();
      t_guard();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule